// File: doc/BRIEF.md
# SPI Master Transfer Engine with End-Marked Transmit Queue

This block is an SPI master that moves words of a programmable length (4 to 24 bits) between two 8-entry queues and the serial lines. Software fills the transmit queue through a small register port, then issues a start command. Each queued word carries a flag that marks it as the final word of the transfer. The engine shifts words out on MOSI and captures MISO into the receive queue. After the flagged word has been shifted and its received word stored, it releases chip select and raises a completion event. The serial clock is not generated inside the block. Every pulse on the `tick` input is one half period of SCK.

The engine is controlled by a finite-state machine with five states. **IDLE**: chip select is inactive. **LOAD**: the engine takes the next word from the transmit queue. **SHIFT**: the engine clocks the word's bits, one SCK edge per tick. **STORE**: the engine pushes the received word into the receive queue. **PAUSE**: the transmit queue ran dry before the flagged word, and chip select stays active.

The transitions are:
- IDLE→LOAD on an enabled start command.
- LOAD→SHIFT when the transmit queue holds a word.
- LOAD→PAUSE when the transmit queue is empty (transmit underflow).
- SHIFT→STORE on the falling SCK edge after the word's last bit.
- STORE→IDLE after the flagged word.
- STORE→LOAD after any other word.
- PAUSE→LOAD on a new enabled start command.

Events are held in a write-one-to-clear register. The interrupt line is the OR of all events whose mask bit is zero.

Top module: `spi_xfer_engine`

Register map (`addr`):

| Address | Name | Access |
|---|---|---|
| 0 | DATA | write pushes to the transmit queue; read pops the receive queue |
| 1 | CFG | read/write |
| 2 | CMD | write issues commands; read returns pending clears |
| 3 | EVENT | read; write one to clear |
| 4 | MASK | read/write |
| 5 | STATUS | read only |

## Requirements
- R1: CFG[4:0] holds the word length N. Values 4 to 24 are used as given; below 4 acts as 4 and above 24 acts as 24. Only the low N bits of DATA[23:0] are sent. The word read from DATA is the N received bits, right-aligned and zero-extended. The reset value of N is 8.
- R2: A DATA write pushes wdata[23:0] together with a last flag taken from wdata[31]. The transfer ends after the flagged word. EVENT[0] (done) is set in the same cycle that the flagged word's received data becomes readable and the state returns to IDLE. EVENT[0] is never set for a word without the flag.
- R3: CFG[5]=0 sends and receives the most significant bit first. CFG[5]=1 sends and receives the least significant bit first.
- R4: SCK idles low and changes only in cycles where `tick` is high. MOSI is valid before the rising SCK edge. MISO is sampled on the rising edge. Each word takes exactly N rising SCK edges.
- R5: In LOAD with an empty transmit queue, EVENT[1] (transmit underflow) is set and the engine enters PAUSE. Chip select stays active and STATUS[3] stays 1. A start command in PAUSE resumes the transfer.
- R6: A word that completes while the receive queue is full is dropped and sets EVENT[2] (receive overflow). A DATA read from an empty receive queue returns 0, changes nothing else, and sets EVENT[3] (receive underflow).
- R7: EVENT[4] (transmit request) is set on every word taken from the transmit queue. EVENT[5] (receive request) is set on every word stored in the receive queue.
- R8: Writing EVENT clears each bit written as 1 and leaves the other bits unchanged. A set condition in the same cycle takes priority over the clear.
- R9: MASK resets to 0x3F. `irq` is high exactly when some event bit is set whose MASK bit is 0.
- R10: CMD[1] empties the receive queue and CMD[2] empties the transmit queue. These bits read back as 1 in the cycle after the write and as 0 from the following cycle on.
- R11: STATUS bit 0 is ready: 1 when CFG[7] (enable) is set, the state is IDLE and no clear is pending. STATUS bit 1 is transmit-queue full, bit 2 is receive-queue empty, and bit 3 is busy (chip select active).
- R12: Each queue holds 8 entries. A DATA write to a full transmit queue is ignored.
- R13: Chip select is active from the cycle after a start command until the state returns to IDLE. CFG[6]=1 makes it active high and CFG[6]=0 makes it active low. A start command is ignored unless CFG[7] is 1 and the state is IDLE or PAUSE.
- R14: After reset the following hold: STATUS=0x4, EVENT=0, MASK=0x3F, SCK low, chip select inactive, `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive queue at DATA) |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational from addr |
| tick | input | 1 | Half-period strobe for SCK |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs | output | 1 | Chip select, polarity from CFG[6] |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a PAUSE that leaves the receive queue full, followed by a resume that overflows it. The stimulus writes nine words in a row without reading. The ninth write carries the last flag and hits a full transmit queue, so it is discarded. The engine therefore drains eight words and underflows with the receive queue full. A flagged word is then added and the transfer is restarted, which produces both the dropped-word overflow and, after the eight reads, the empty-read underflow. The bench loops MOSI back to MISO and records MOSI at every rising SCK edge, so that bit order and bit count are checked separately from the received data.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    typedef enum logic [2:0] {ST_IDLE, ST_LOAD, ST_SHIFT, ST_STORE, ST_PAUSE} eng_state_t;

    localparam logic [2:0] A_DATA   = 3'd0;
    localparam logic [2:0] A_CFG    = 3'd1;
    localparam logic [2:0] A_CMD    = 3'd2;
    localparam logic [2:0] A_EVENT  = 3'd3;
    localparam logic [2:0] A_MASK   = 3'd4;
    localparam logic [2:0] A_STATUS = 3'd5;

    localparam int EV_DONE = 0;
    localparam int EV_TXUF = 1;
    localparam int EV_RXOF = 2;
    localparam int EV_RXUF = 3;
    localparam int EV_TXRQ = 4;
    localparam int EV_RXRQ = 5;
    localparam int N_EV    = 6;
endpackage

// File: rtl/spi_eng_fifo.sv
module spi_eng_fifo #(
    parameter int W     = 25,
    parameter int DEPTH = 8,
    parameter int LVW   = $clog2(DEPTH) + 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           push,
    input  logic [W-1:0]   din,
    input  logic           pop,
    output logic [W-1:0]   dout,
    output logic           full,
    output logic           empty,
    output logic [LVW-1:0] level
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == LVW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wp] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else if (clr) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            level <= level + LVW'(do_push) - LVW'(do_pop);
        end
    end
endmodule

// File: rtl/spi_eng_events.sv
module spi_eng_events #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic         clr_en,
    input  logic [N-1:0] clr_bits,
    input  logic [N-1:0] mask,
    output logic [N-1:0] ev,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_ev
        logic bit_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                    bit_q <= 1'b0;
            else if (set[i])               bit_q <= 1'b1;
            else if (clr_en && clr_bits[i]) bit_q <= 1'b0;
        end
        assign ev[i] = bit_q;
    end

    assign irq = |(ev & ~mask);
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter int MAXW  = 24,
    parameter int DEPTH = 8,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [2:0]    addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic          tick,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          cs,
    output logic          irq
);
    localparam int LENW  = $clog2(MAXW + 1);
    localparam int LVW   = $clog2(DEPTH) + 1;
    localparam int FW    = MAXW + 1;
    localparam int CFG_W = LENW + 3;
    localparam int MINW  = 4;

    eng_state_t state, state_nx;

    logic [CFG_W-1:0] cfg_q;
    logic [N_EV-1:0]  mask_q, ev_q, ev_set;
    logic             clr_rx_p, clr_tx_p;
    logic [MAXW-1:0]  word_q, rx_word, rx_dout;
    logic             last_q;
    logic [LENW-1:0]  bit_idx, eff_len, last_idx, pos;
    logic [FW-1:0]    tx_dout;
    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [LVW-1:0]   tx_level, rx_level;
    logic             cs_act, ready;

    wire [LENW-1:0] cfg_len  = cfg_q[LENW-1:0];
    wire            cfg_lsb  = cfg_q[LENW];
    wire            cfg_cshi = cfg_q[LENW+1];
    wire            cfg_en   = cfg_q[LENW+2];

    wire wr_data  = wr_en && (addr == A_DATA);
    wire wr_cfg   = wr_en && (addr == A_CFG);
    wire wr_cmd   = wr_en && (addr == A_CMD);
    wire wr_ev    = wr_en && (addr == A_EVENT);
    wire wr_mask  = wr_en && (addr == A_MASK);
    wire rd_data  = rd_en && (addr == A_DATA);
    wire go_start = wr_cmd && wdata[0] && cfg_en;
    wire tx_pop   = (state == ST_LOAD) && !tx_empty;
    wire rx_push  = (state == ST_STORE);
    wire bit_end  = (state == ST_SHIFT) && tick && sclk && (bit_idx == last_idx);

    always_comb begin
        if (cfg_len < LENW'(MINW))      eff_len = LENW'(MINW);
        else if (cfg_len > LENW'(MAXW)) eff_len = LENW'(MAXW);
        else                            eff_len = cfg_len;
    end
    assign last_idx = eff_len - 1'b1;
    assign pos      = cfg_lsb ? bit_idx : (last_idx - bit_idx);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (go_start) state_nx = ST_LOAD;
            ST_LOAD:  state_nx = tx_empty ? ST_PAUSE : ST_SHIFT;
            ST_SHIFT: if (bit_end) state_nx = ST_STORE;
            ST_STORE: state_nx = last_q ? ST_IDLE : ST_LOAD;
            ST_PAUSE: if (go_start) state_nx = ST_LOAD;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs and datapath
    assign cs_act = (state != ST_IDLE);
    assign cs     = cfg_cshi ? cs_act : !cs_act;
    assign mosi   = (state == ST_SHIFT) ? word_q[pos] : 1'b0;
    assign ready  = cfg_en && (state == ST_IDLE) && !clr_rx_p && !clr_tx_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk    <= 1'b0;
            word_q  <= '0;
            rx_word <= '0;
            last_q  <= 1'b0;
            bit_idx <= '0;
        end else if (tx_pop) begin
            word_q  <= tx_dout[MAXW-1:0];
            last_q  <= tx_dout[MAXW];
            rx_word <= '0;
            bit_idx <= '0;
            sclk    <= 1'b0;
        end else if ((state == ST_SHIFT) && tick) begin
            sclk <= !sclk;
            if (!sclk)                    rx_word[pos] <= miso;
            else if (bit_idx != last_idx) bit_idx <= bit_idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q    <= CFG_W'(8);
            mask_q   <= '1;
            clr_rx_p <= 1'b0;
            clr_tx_p <= 1'b0;
        end else begin
            if (wr_cfg)  cfg_q  <= wdata[CFG_W-1:0];
            if (wr_mask) mask_q <= wdata[N_EV-1:0];
            clr_rx_p <= wr_cmd && wdata[1];
            clr_tx_p <= wr_cmd && wdata[2];
        end
    end

    always_comb begin
        ev_set          = '0;
        ev_set[EV_DONE] = rx_push && last_q;
        ev_set[EV_TXUF] = (state == ST_LOAD) && tx_empty;
        ev_set[EV_RXOF] = rx_push && rx_full;
        ev_set[EV_RXUF] = rd_data && rx_empty;
        ev_set[EV_TXRQ] = tx_pop;
        ev_set[EV_RXRQ] = rx_push && !rx_full;
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_DATA:   rdata = rx_empty ? '0 : DW'(rx_dout);
            A_CFG:    rdata = DW'(cfg_q);
            A_CMD:    rdata = DW'({clr_tx_p, clr_rx_p, 1'b0});
            A_EVENT:  rdata = DW'(ev_q);
            A_MASK:   rdata = DW'(mask_q);
            A_STATUS: rdata = DW'({cs_act, rx_empty, tx_full, ready});
            default:  rdata = '0;
        endcase
    end

    spi_eng_fifo #(.W(FW), .DEPTH(DEPTH), .LVW(LVW)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(clr_tx_p), .push(wr_data),
        .din({wdata[DW-1], wdata[MAXW-1:0]}), .pop(tx_pop),
        .dout(tx_dout), .full(tx_full), .empty(tx_empty), .level(tx_level)
    );

    spi_eng_fifo #(.W(MAXW), .DEPTH(DEPTH), .LVW(LVW)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(clr_rx_p), .push(rx_push),
        .din(rx_word), .pop(rd_data),
        .dout(rx_dout), .full(rx_full), .empty(rx_empty), .level(rx_level)
    );

    spi_eng_events #(.N(N_EV)) u_ev (
        .clk(clk), .rst_n(rst_n), .set(ev_set), .clr_en(wr_ev),
        .clr_bits(wdata[N_EV-1:0]), .mask(mask_q), .ev(ev_q), .irq(irq)
    );
endmodule

// File: rtl/spi_xfer_chk.sv
module spi_xfer_chk
    import spi_eng_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int LVW   = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick,
    input logic            sclk,
    input logic            cs_act,
    input eng_state_t      state,
    input logic [N_EV-1:0] ev,
    input logic            clr_rx_p,
    input logic [LVW-1:0]  rx_level,
    input logic [LVW-1:0]  tx_level
);
    // R4
    sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act |-> !sclk);

    // R4
    sclk_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(sclk));

    // R2
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev[EV_DONE]) |-> (state == ST_IDLE));

    // R5
    uf_pause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev[EV_TXUF]) |-> (state == ST_PAUSE));

    // R10
    rx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_rx_p |=> (rx_level == '0));

    // R12
    tx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_level <= LVW'(DEPTH));
endmodule

bind spi_xfer_engine spi_xfer_chk #(.DEPTH(DEPTH), .LVW(LVW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sclk(sclk), .cs_act(cs_act),
    .state(state), .ev(ev_q), .clr_rx_p(clr_rx_p), .rx_level(rx_level),
    .tx_level(tx_level)
);

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;
    logic        clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, tick = 0;
    logic [2:0]  addr = 0;
    logic [31:0] wdata = 0;
    wire  [31:0] rdata;
    wire         sclk, mosi, cs, irq;
    wire         miso = mosi;

    int errs = 0, checks = 0, ncap = 0;
    logic [23:0] cap = 0;

    // {len[4:0], lsb_first, data[23:0]}
    localparam logic [29:0] VEC [6] = '{
        {5'd8,  1'b0, 24'h0000A5},
        {5'd8,  1'b1, 24'h0003C1},
        {5'd4,  1'b0, 24'h000009},
        {5'd24, 1'b0, 24'hC3A5F1},
        {5'd24, 1'b1, 24'h12345E},
        {5'd13, 1'b1, 24'h001ABC}
    };

    always #5 clk = ~clk;

    spi_xfer_engine u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs(cs), .irq(irq)
    );

    always @(posedge sclk) begin
        cap  = {cap[22:0], mosi};
        ncap = ncap + 1;
    end

    initial forever begin
        @(negedge clk);
        tick = ~tick;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1;
        @(posedge clk);
        #1 wr_en = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1;
        #1 d = rdata;
        @(posedge clk);
        #1 rd_en = 0;
    endtask

    task automatic wait_ev(input int idx);
        logic [31:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(3, v);
            if (v[idx]) break;
        end
    endtask

    function automatic logic [23:0] rev(input logic [23:0] d, input int n);
        logic [23:0] r = '0;
        for (int i = 0; i < n; i++) r[n-1-i] = d[i];
        return r;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [23:0] d, m, e;
        logic [4:0]  len;
        logic        lsb;

        repeat (4) @(negedge clk);
        check("R14 cs idle", {31'b0, cs}, 1);
        check("R14 sclk", {31'b0, sclk}, 0);
        check("R14 irq", {31'b0, irq}, 0);
        rst_n = 1;
        rd(5, v); check("R14 status", v, 32'h4);
        rd(4, v); check("R14 mask", v, 32'h3F);
        rd(3, v); check("R14 event", v, 0);

        // R13: start ignored while disabled
        wr(0, {1'b1, 7'b0, 24'h11});
        wr(2, 1);
        check("R13 start ignored when disabled", {31'b0, cs}, 1);
        wr(2, 4);                                   // drop queued word
        wr(1, 32'h88);
        rd(5, v); check("R11 ready", v, 32'h5);

        // table-driven transfers
        for (int k = 0; k < 6; k++) begin
            len = VEC[k][29:25];
            lsb = VEC[k][24];
            d   = VEC[k][23:0];
            m   = 24'hFFFFFF >> (24 - len);
            e   = d & m;
            wr(1, {24'b0, 1'b1, 1'b0, lsb, len});
            wr(0, {1'b1, 7'b0, d});
            cap = 0; ncap = 0;
            wr(2, 1);
            check("R13 cs active low", {31'b0, cs}, 0);
            wait_ev(0);
            rd(0, v); check("R1 rx word", v, {8'b0, e});
            check("R3 bit order", {8'b0, cap & m}, {8'b0, lsb ? rev(e, len) : e});
            check("R4 edge count", ncap, {27'b0, len});
            if (k == 0) begin
                rd(3, v); check("R7 events after one word", v, 32'h31);
                check("R4 sclk idle", {31'b0, sclk}, 0);
            end
            wr(3, 32'h3F);
        end

        // R12/R5/R6 chain: full queue, underflow, overflow
        wr(1, 32'h88);
        for (int i = 0; i < 8; i++) wr(0, 32'h10 + i);
        wr(0, {1'b1, 7'b0, 24'h99});
        rd(5, v); check("R12 tx full", {31'b0, v[1]}, 1);
        wr(2, 1);
        wait_ev(1);
        rd(3, v); check("R2 no done without flag", {31'b0, v[0]}, 0);
        check("R5 cs held in pause", {31'b0, cs}, 0);
        rd(5, v); check("R5 busy in pause", {31'b0, v[3]}, 1);
        wr(0, {1'b1, 7'b0, 24'h77});
        wr(2, 1);
        wait_ev(0);
        rd(3, v); check("R6 rx overflow", {31'b0, v[2]}, 1);
        for (int i = 0; i < 8; i++) begin
            rd(0, v); check("R12 rx content", v, 32'h10 + i);
        end
        rd(0, v); check("R6 empty read value", v, 0);
        rd(3, v); check("R6 rx underflow", {31'b0, v[3]}, 1);
        wr(3, 32'h3F);

        // R9/R8 irq and write-one-to-clear
        rd(0, v);
        check("R9 irq masked", {31'b0, irq}, 0);
        wr(4, 32'h37);
        check("R9 irq unmasked", {31'b0, irq}, 1);
        wr(4, 32'h3F);
        check("R9 irq remasked", {31'b0, irq}, 0);
        wr(4, 32'h37);
        wr(3, 32'h01);
        rd(3, v); check("R8 other bit kept", v, 32'h08);
        wr(3, 32'h08);
        rd(3, v); check("R8 bit cleared", v, 0);
        check("R9 irq after clear", {31'b0, irq}, 0);
        wr(4, 32'h3F);

        // R10 clears
        wr(0, {1'b1, 7'b0, 24'h5A});
        wr(2, 1);
        wait_ev(0);
        wr(3, 32'h3F);
        for (int i = 0; i < 3; i++) wr(0, 32'h20 + i);
        wr(2, 6);
        rd(2, v); check("R10 clear pending", v, 6);
        rd(2, v); check("R10 clear finished", v, 0);
        rd(5, v); check("R10 rx empty, ready", v, 32'h5);
        wr(2, 1);
        wait_ev(1);
        rd(3, v); check("R10 tx emptied", {31'b0, v[1]}, 1);
        wr(0, {1'b1, 7'b0, 24'h05});
        wr(2, 1);
        wait_ev(0);
        rd(0, v);
        wr(3, 32'h3F);

        // R13 active-high chip select
        wr(1, 32'hC8);
        check("R13 cs idle high-pol", {31'b0, cs}, 0);
        wr(0, {1'b1, 7'b0, 24'h12});
        wr(2, 1);
        check("R13 cs active high", {31'b0, cs}, 1);
        wait_ev(0);
        check("R13 cs released", {31'b0, cs}, 0);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule